// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Layer

This block is the lowest layer of a slave on a shared open-drain single-wire bus. The data line is read through a clocked synchronizer, and every low period driven by the master is measured in system-clock cycles. The length of each low decides what it was: a bus reset, a written one, a written zero, or a glitch to be discarded. The block answers a reset with a presence pulse. During a read slot the block can stretch the master's short low, so that the master reads a zero. The block never drives the line high. It only enables a pull-down.

The command layer above the block does four things. It selects overdrive speed with a one-cycle pulse. It says whether the next slot is a read slot. It supplies the bit to return in that slot. It collects received bits, which are sent least significant bit first. Every time window is set in microseconds and converted to clock cycles through a clocks-per-microsecond parameter.

Top module: `swire_slave_phy`

## Requirements
- R1: After reset the pull-down is off and no strobe is active. The block is at standard speed, so `od_o` is 0.
- R2: At standard speed, a low of at least RST_STD_US microseconds gives a one-cycle `bus_rst_o`. A low of RST_OD_US or longer, but shorter than RST_STD_US, is not a reset and decodes as a zero bit.
- R3: At overdrive speed, a low of at least RST_OD_US microseconds is a reset. When the low also reaches RST_STD_US, the same edge clears overdrive. A shorter reset leaves overdrive set.
- R4: After a reset, the block waits the presence-gap time and then drives `pull_o` for the presence-length time. Both times use the speed in force after the reset.
- R5: In a write slot, a low shorter than the write-one minimum gives nothing. A low from that minimum up to, but not including, the sample point gives `bit_vld_o` with `bit_o`=1. A longer low that is not a reset gives `bit_o`=0.
- R6: When `rd_slot_i` is high at the start of a low, the block pulses `rd_req_o` for one cycle and produces no received-bit strobe. If `rd_bit_i` is 0, `pull_o` is held for the read-hold time. If it is 1, the line is left alone.
- R7: A pulse on `od_set_i` selects overdrive windows from the next cycle on. The current speed is shown on `od_o`.
- R8: Each result lands a fixed number of cycles after the line input changes. That is SYNC_STAGES cycles after the master releases the line, with each window equal to its microsecond value multiplied by CLK_PER_US.
- R9: While the block's own presence pulse holds the line low, that low is not decoded. No slot starts until the line has been seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Level of the bus data line |
| pull_o | output | 1 | Pull-down enable for the open-drain driver |
| od_set_i | input | 1 | One-cycle request to switch to overdrive speed |
| od_o | output | 1 | High while overdrive speed is active |
| rd_slot_i | input | 1 | Treat the next slot as a read slot |
| rd_bit_i | input | 1 | Bit to return in the next read slot |
| rd_req_o | output | 1 | One-cycle pulse: read bit taken, supply the next one |
| bit_vld_o | output | 1 | One-cycle strobe: a written bit was received |
| bit_o | output | 1 | Value of the received bit, valid with `bit_vld_o` |
| bus_rst_o | output | 1 | One-cycle pulse: a bus reset was detected |

## Verification
Results are counted from the first clock edge that samples the master's low, called e0. For a low of N cycles, the bit strobe or reset pulse appears SYNC_STAGES+N cycles after e0. A read request, and the start of a read-hold pull, appear SYNC_STAGES cycles after e0. The presence pull starts the presence-gap count after the reset pulse and lasts the presence-length count. The bench builds these target cycles from the stimulus and the requirement constants. It compares every output against them at each falling clock edge, so the outputs are sampled away from the edge that updates them. Boundary lows are placed exactly on each threshold and one cycle below it.

// File: rtl/swire_pkg.sv
package swire_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_PD_WAIT,
      ST_PD_DRIVE,
      ST_RELEASE
   } sw_state_e;

   function automatic int unsigned us_to_clk(input int unsigned us, input int unsigned cpu);
      return us * cpu;
   endfunction

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("swire_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/swire_timing.sv
module swire_timing #(
   parameter int unsigned CLK_PER_US  = 125,
   parameter int unsigned CW          = 18,
   parameter int unsigned RST_STD_US  = 480,
   parameter int unsigned RST_OD_US   = 48,
   parameter int unsigned GLT_STD_US  = 5,
   parameter int unsigned GLT_OD_US   = 1,
   parameter int unsigned SMP_STD_US  = 30,
   parameter int unsigned SMP_OD_US   = 4,
   parameter int unsigned HLD_STD_US  = 30,
   parameter int unsigned HLD_OD_US   = 3,
   parameter int unsigned PDH_STD_US  = 30,
   parameter int unsigned PDH_OD_US   = 3,
   parameter int unsigned PDL_STD_US  = 120,
   parameter int unsigned PDL_OD_US   = 12
) (
   input  logic          od_i,
   output logic [CW-1:0] rst_lim_o,
   output logic [CW-1:0] std_rst_lim_o,
   output logic [CW-1:0] glt_lim_o,
   output logic [CW-1:0] smp_lim_o,
   output logic [CW-1:0] hld_lim_o,
   output logic [CW-1:0] pdh_lim_o,
   output logic [CW-1:0] pdl_lim_o
);
   import swire_pkg::*;

   localparam int unsigned C_RST_STD = us_to_clk(RST_STD_US, CLK_PER_US);
   localparam int unsigned C_RST_OD  = us_to_clk(RST_OD_US,  CLK_PER_US);
   localparam int unsigned C_GLT_STD = us_to_clk(GLT_STD_US, CLK_PER_US);
   localparam int unsigned C_GLT_OD  = us_to_clk(GLT_OD_US,  CLK_PER_US);
   localparam int unsigned C_SMP_STD = us_to_clk(SMP_STD_US, CLK_PER_US);
   localparam int unsigned C_SMP_OD  = us_to_clk(SMP_OD_US,  CLK_PER_US);
   localparam int unsigned C_HLD_STD = us_to_clk(HLD_STD_US, CLK_PER_US);
   localparam int unsigned C_HLD_OD  = us_to_clk(HLD_OD_US,  CLK_PER_US);
   localparam int unsigned C_PDH_STD = us_to_clk(PDH_STD_US, CLK_PER_US);
   localparam int unsigned C_PDH_OD  = us_to_clk(PDH_OD_US,  CLK_PER_US);
   localparam int unsigned C_PDL_STD = us_to_clk(PDL_STD_US, CLK_PER_US);
   localparam int unsigned C_PDL_OD  = us_to_clk(PDL_OD_US,  CLK_PER_US);

   generate
      if (C_GLT_OD == 0 || C_PDH_OD == 0 || C_PDL_OD == 0 || C_HLD_OD == 0) begin : g_zero
         $error("swire_timing: an overdrive window rounds to zero cycles");
      end
      if (C_PDL_STD >= C_RST_STD || C_PDH_STD >= C_RST_STD) begin : g_pd
         $error("swire_timing: presence windows must be shorter than the reset window");
      end
   endgenerate

   assign std_rst_lim_o = CW'(C_RST_STD);
   assign rst_lim_o     = od_i ? CW'(C_RST_OD)  : CW'(C_RST_STD);
   assign glt_lim_o     = od_i ? CW'(C_GLT_OD)  : CW'(C_GLT_STD);
   assign smp_lim_o     = od_i ? CW'(C_SMP_OD)  : CW'(C_SMP_STD);
   assign hld_lim_o     = od_i ? CW'(C_HLD_OD)  : CW'(C_HLD_STD);
   assign pdh_lim_o     = od_i ? CW'(C_PDH_OD)  : CW'(C_PDH_STD);
   assign pdl_lim_o     = od_i ? CW'(C_PDL_OD)  : CW'(C_PDL_STD);
endmodule

// File: rtl/swire_slave_phy.sv
module swire_slave_phy #(
   parameter int unsigned CLK_PER_US  = 125,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_STD_US  = 480,
   parameter int unsigned RST_OD_US   = 48,
   parameter int unsigned GLT_STD_US  = 5,
   parameter int unsigned GLT_OD_US   = 1,
   parameter int unsigned SMP_STD_US  = 30,
   parameter int unsigned SMP_OD_US   = 4,
   parameter int unsigned HLD_STD_US  = 30,
   parameter int unsigned HLD_OD_US   = 3,
   parameter int unsigned PDH_STD_US  = 30,
   parameter int unsigned PDH_OD_US   = 3,
   parameter int unsigned PDL_STD_US  = 120,
   parameter int unsigned PDL_OD_US   = 12
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic pull_o,
   input  logic od_set_i,
   output logic od_o,
   input  logic rd_slot_i,
   input  logic rd_bit_i,
   output logic rd_req_o,
   output logic bit_vld_o,
   output logic bit_o,
   output logic bus_rst_o
);
   import swire_pkg::*;

   localparam int unsigned CW = $clog2(RST_STD_US * CLK_PER_US + 1) + 1;

   generate
      if (RST_OD_US >= RST_STD_US) begin : g_rst_order
         $error("swire_slave_phy: overdrive reset must be shorter than standard reset");
      end
      if (GLT_STD_US >= SMP_STD_US || GLT_OD_US >= SMP_OD_US) begin : g_smp_order
         $error("swire_slave_phy: sample point must lie above the glitch limit");
      end
      if (SMP_STD_US >= RST_OD_US) begin : g_smp_rst
         $error("swire_slave_phy: sample point must lie below every reset limit");
      end
   endgenerate

   logic          ln;
   sw_state_e     state_q;
   logic [CW-1:0] cnt_q, tmr_q;
   logic          drv_q, od_q, rmode_q;
   logic          bit_vld_q, bit_q, bus_rst_q, rd_req_q;
   logic [CW-1:0] rst_lim, std_rst_lim, glt_lim, smp_lim, hld_lim, pdh_lim, pdl_lim;

   swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_i),
      .q_o   (ln)
   );

   swire_timing #(
      .CLK_PER_US(CLK_PER_US), .CW(CW),
      .RST_STD_US(RST_STD_US), .RST_OD_US(RST_OD_US),
      .GLT_STD_US(GLT_STD_US), .GLT_OD_US(GLT_OD_US),
      .SMP_STD_US(SMP_STD_US), .SMP_OD_US(SMP_OD_US),
      .HLD_STD_US(HLD_STD_US), .HLD_OD_US(HLD_OD_US),
      .PDH_STD_US(PDH_STD_US), .PDH_OD_US(PDH_OD_US),
      .PDL_STD_US(PDL_STD_US), .PDL_OD_US(PDL_OD_US)
   ) u_timing (
      .od_i         (od_q),
      .rst_lim_o    (rst_lim),
      .std_rst_lim_o(std_rst_lim),
      .glt_lim_o    (glt_lim),
      .smp_lim_o    (smp_lim),
      .hld_lim_o    (hld_lim),
      .pdh_lim_o    (pdh_lim),
      .pdl_lim_o    (pdl_lim)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         tmr_q     <= '0;
         drv_q     <= 1'b0;
         od_q      <= 1'b0;
         rmode_q   <= 1'b0;
         bit_vld_q <= 1'b0;
         bit_q     <= 1'b0;
         bus_rst_q <= 1'b0;
         rd_req_q  <= 1'b0;
      end else begin
         bit_vld_q <= 1'b0;
         bus_rst_q <= 1'b0;
         rd_req_q  <= 1'b0;
         if (od_set_i) od_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               if (!ln) begin
                  state_q <= ST_LOW;
                  cnt_q   <= CW'(1);
                  rmode_q <= rd_slot_i;
                  if (rd_slot_i) begin
                     rd_req_q <= 1'b1;
                     drv_q    <= !rd_bit_i;
                  end
               end
            end
            ST_LOW: begin
               if (ln) begin
                  drv_q <= 1'b0;
                  if (cnt_q >= rst_lim) begin
                     bus_rst_q <= 1'b1;
                     state_q   <= ST_PD_WAIT;
                     tmr_q     <= '0;
                     if (cnt_q >= std_rst_lim) od_q <= 1'b0;
                  end else begin
                     state_q <= ST_IDLE;
                     if (!rmode_q && cnt_q >= glt_lim) begin
                        bit_vld_q <= 1'b1;
                        bit_q     <= (cnt_q < smp_lim);
                     end
                  end
               end else begin
                  if (cnt_q < std_rst_lim) cnt_q <= cnt_q + 1'b1;
                  if (drv_q && cnt_q >= hld_lim) drv_q <= 1'b0;
               end
            end
            ST_PD_WAIT: begin
               if (tmr_q == pdh_lim - 1'b1) begin
                  state_q <= ST_PD_DRIVE;
                  tmr_q   <= '0;
                  drv_q   <= 1'b1;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_PD_DRIVE: begin
               if (tmr_q == pdl_lim - 1'b1) begin
                  state_q <= ST_RELEASE;
                  drv_q   <= 1'b0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_RELEASE: begin
               if (ln) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign pull_o    = drv_q;
   assign od_o      = od_q;
   assign rd_req_o  = rd_req_q;
   assign bit_vld_o = bit_vld_q;
   assign bit_o     = bit_q;
   assign bus_rst_o = bus_rst_q;

   // R5 R6: at most one kind of event per cycle
   a_r5_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({bit_vld_o, bus_rst_o, rd_req_o}));

   // R3: overdrive only drops on the edge that reports a reset
   a_r3_od_drop_on_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(od_o) |-> bus_rst_o);

   // R4: the presence pull never begins in the cycle the reset is reported
   a_r4_gap_before_presence: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_rst_o |-> !pull_o);

   // R2: reset report is a single-cycle pulse
   a_r2_reset_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_rst_o |=> !bus_rst_o);

   // R6: read request is a single-cycle pulse
   a_r6_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_o |=> !rd_req_o);

   // R9: nothing decoded while the presence pulse is on the line
   a_r9_quiet_presence: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_PD_DRIVE) |-> !bit_vld_o);
endmodule

// File: tb/tb_swire_slave_phy.sv
`timescale 1ns/1ps
module tb_swire_slave_phy;
   // bench constants, written from the requirements
   localparam int CPU    = 8;
   localparam int SYNC   = 2;
   localparam int RSTS   = 480 * CPU;
   localparam int RSTO   = 48 * CPU;
   localparam int GLS    = 5 * CPU,   GLO = 1 * CPU;
   localparam int SMS    = 30 * CPU,  SMO = 4 * CPU;
   localparam int HLS    = 30 * CPU,  HLO = 3 * CPU;
   localparam int PHS    = 30 * CPU,  PHO = 3 * CPU;
   localparam int PLS    = 120 * CPU, PLO = 12 * CPU;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_low = 1'b0;
   logic od_set = 1'b0, rd_slot = 1'b0, rd_bit = 1'b1;
   logic pull, od, rd_req, bit_vld, bit_v, bus_rst;
   wire  line = !(m_low || pull);

   always #4 clk = !clk;

   swire_slave_phy #(.CLK_PER_US(CPU), .SYNC_STAGES(SYNC)) dut (
      .clk_i(clk), .rst_ni(rst_n), .line_i(line), .pull_o(pull),
      .od_set_i(od_set), .od_o(od), .rd_slot_i(rd_slot), .rd_bit_i(rd_bit),
      .rd_req_o(rd_req), .bit_vld_o(bit_vld), .bit_o(bit_v), .bus_rst_o(bus_rst)
   );

   int cyc = 0;
   int vectors = 0, fails = 0;
   int pw_lo = -1, pw_hi = -1, bit_cyc = -1, rst_cyc = -1, req_cyc = -1, odclr_cyc = -1;
   logic exp_bitv = 1'b0;
   logic m_od = 1'b0;
   logic checking = 1'b0;
   logic done = 1'b0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == odclr_cyc) m_od = 1'b0;
      else if (od_set && rst_n) m_od = 1'b1;
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cyc=%0d act=%0b exp=%0b", tag, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (checking && !done) begin
         chk("R4 R6 R9 pull", pull, (cyc >= pw_lo && cyc < pw_hi));
         chk("R5 R8 R9 bit_vld", bit_vld, (cyc == bit_cyc));
         if (cyc == bit_cyc) chk("R5 bit value", bit_v, exp_bitv);
         chk("R2 R3 bus_rst", bus_rst, (cyc == rst_cyc));
         chk("R6 rd_req", rd_req, (cyc == req_cyc));
         chk("R3 R7 od", od, m_od);
      end
   end

   // master low of n cycles; read slot when rd is set
   task automatic slot(input int n, input logic rd, input logic b);
      int e0, rl, ph, pl;
      @(negedge clk);
      rd_slot = rd; rd_bit = b;
      m_low = 1'b1;
      e0 = cyc + 1;
      rl = m_od ? RSTO : RSTS;
      if (rd) begin
         req_cyc = e0 + SYNC;
         if (!b) begin
            pw_lo = e0 + SYNC;
            pw_hi = e0 + SYNC + (m_od ? HLO : HLS);
         end
      end else if (n >= rl) begin
         rst_cyc = e0 + n + SYNC;
         if (n >= RSTS) odclr_cyc = rst_cyc;
         ph = (n >= RSTS || !m_od) ? PHS : PHO;
         pl = (n >= RSTS || !m_od) ? PLS : PLO;
         pw_lo = rst_cyc + ph;
         pw_hi = pw_lo + pl;
      end else if (n >= (m_od ? GLO : GLS)) begin
         bit_cyc  = e0 + n + SYNC;
         exp_bitv = (n < (m_od ? SMO : SMS));
      end
      repeat (n) @(negedge clk);
      m_low = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      rd_slot = 1'b0;
      repeat (((n >= rl) && !rd) ? PHS + PLS + 20 : HLS + 20) @(negedge clk);
   endtask

   task automatic go_od();
      @(negedge clk); od_set = 1'b1;
      @(negedge clk); od_set = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 pull idle", pull, 1'b0);
      chk("R1 od idle", od, 1'b0);
      chk("R1 no strobe", bit_vld | bus_rst | rd_req, 1'b0);
      checking = 1'b1;
      repeat (5) @(negedge clk);
      // R2 R4: standard reset and presence
      slot(4000, 1'b0, 1'b1);
      // R5: write decode at standard speed, LSB-first byte 0xA5 and boundaries
      slot(GLS - 1, 1'b0, 1'b1);      // glitch
      slot(GLS, 1'b0, 1'b1);          // 1 at minimum
      slot(SMS - 1, 1'b0, 1'b1);      // 1 just below sample point
      slot(SMS, 1'b0, 1'b1);          // 0 at sample point
      for (int i = 0; i < 8; i++) slot((8'hA5 >> i) & 1 ? 80 : 600, 1'b0, 1'b1);
      // R2: overdrive-length low at standard speed is a zero bit, not a reset
      slot(RSTO + 16, 1'b0, 1'b1);
      slot(RSTS - 1, 1'b0, 1'b1);
      slot(RSTS, 1'b0, 1'b1);
      // R6: read slots at standard speed
      slot(16, 1'b1, 1'b0);
      slot(16, 1'b1, 1'b1);
      // R7: overdrive
      go_od();
      slot(GLO - 1, 1'b0, 1'b1);
      slot(GLO, 1'b0, 1'b1);
      slot(SMO - 1, 1'b0, 1'b1);
      slot(SMO, 1'b0, 1'b1);
      slot(4, 1'b1, 1'b0);
      slot(4, 1'b1, 1'b1);
      // R3: overdrive reset keeps overdrive
      slot(RSTO - 1, 1'b0, 1'b1);
      slot(RSTO, 1'b0, 1'b1);
      slot(12, 1'b0, 1'b1);
      // R3: standard-length reset clears overdrive
      slot(RSTS + 40, 1'b0, 1'b1);
      slot(40, 1'b0, 1'b1);
      repeat (10) @(negedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired cyc=%0d act=running exp=finished", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule